// File: doc/BRIEF.md
# PWM Emergency Break Controller

This block is the last stage between four PWM generators and their output pins. On a hardware fault it overrides the generated waveforms. An external break input is brought into the clock domain and compared with a programmable active level. When the pin is enabled and the input reaches that level, a sticky break-active flag is set. While the flag is set, every channel whose output enable is high drives its bit of a programmable safe-state pattern in place of its raw PWM waveform. Channels with the output enable low always drive 0.

Software reaches the block through one 8-bit control register on a minimal write/read bus. The register holds the safe pattern, the pin enable, the break flag and the level select. Software can clear the flag, and it can also set the flag to force a break even when the pin is disabled. The channel count and the synchronizer depth are parameters. The register layout moves with the channel count, and the values below apply at the defaults.

Top module: `pwm_break_guard`

## Requirements
- R1: After reset the control register reads 00h and every output is 0.
- R2: Bit 7 of the control register is reserved and always reads 0, whatever is written to it.
- R3: A write stores bit 6 (level select), bit 5 (break flag), bit 4 (pin enable) and bits 3:0 (safe pattern), and they read back in the cycle that follows the write edge. During a write cycle the written flag value wins over any hardware set.
- R4: The level select decides which input level counts as active. Bit 6 = 0 makes a low break input active, and bit 6 = 1 makes a high input active.
- R5: While bit 4 (pin enable) is 0, the break input never sets the flag.
- R6: The break input passes through a two-stage synchronizer. Suppose the input is at the active level before rising edge k and the pin is enabled. The flag then reads 0 after edge k+1 and reads 1 after edge k+2.
- R7: Once set, the flag stays set after the input returns to its inactive level, until software writes 0 to it.
- R8: Writing 0 to the flag clears it. If the synchronized input is still active, the flag reads 0 for one cycle and is set again at the next edge.
- R9: Writing 1 to the flag forces a break even when the pin enable is 0.
- R10: While the flag is 1, each output whose enable is 1 equals its bit of the safe pattern (channel x takes bit x).
- R11: An output whose enable is 0 drives 0, whether or not a break is active.
- R12: While the flag is 0, each enabled output equals its raw PWM input in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current control register contents |
| pwm_in | input | 4 | Raw PWM waveforms from the generators |
| pwm_oe | input | 4 | Per-channel output enables |
| brk_in | input | 1 | Asynchronous external break input |
| pwm_out | output | 4 | Gated waveforms to the pins |

## Verification
The bench targets the exact latency of the synchronizer. A design with one stage too many or too few would set the flag an edge late or early. It also checks the case where software clears the flag while the input is still active. A design that let the pin win over the write would never show the single cleared cycle. A design that ignored the pin after the write would leave the flag cleared during a live fault. The bench flips the level select with the input held high to catch an inverted level compare. It drops enables during a break, which exposes a design that forces disabled channels to the pattern. Random traffic also compares every cycle against a behavioural model, which catches a stray register in the pass-through path.

// File: rtl/brk_pkg.sv
`timescale 1ns/1ps
package brk_pkg;
   // Field positions of the control register for a given channel count.
   function automatic int unsigned pen_pos(input int unsigned nch);
      return nch;
   endfunction
   function automatic int unsigned flag_pos(input int unsigned nch);
      return nch + 1;
   endfunction
   function automatic int unsigned lvl_pos(input int unsigned nch);
      return nch + 2;
   endfunction
   function automatic int unsigned rsvd_pos(input int unsigned nch);
      return nch + 3;
   endfunction

   typedef enum logic {
      LVL_LOW  = 1'b0,
      LVL_HIGH = 1'b1
   } brk_level_e;
endpackage

// File: rtl/brk_sync.sv
`timescale 1ns/1ps
module brk_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial begin
      if (STAGES < 2) $fatal(1, "brk_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/brk_ctrl_reg.sv
`timescale 1ns/1ps
module brk_ctrl_reg
   import brk_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   localparam int unsigned REG_W = NUM_CH + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REG_W-1:0]  wdata,
   input  logic              pin_sync,
   output logic [REG_W-1:0]  rdata,
   output logic              brk_active,
   output logic [NUM_CH-1:0] pattern
);
   localparam int unsigned PEN  = pen_pos(NUM_CH);
   localparam int unsigned FLAG = flag_pos(NUM_CH);
   localparam int unsigned LVL  = lvl_pos(NUM_CH);

   initial begin
      if (NUM_CH < 1) $fatal(1, "brk_ctrl_reg: NUM_CH must be at least 1");
   end

   brk_level_e        level_q;
   logic              pen_q;
   logic              flag_q;
   logic [NUM_CH-1:0] pat_q;
   logic              pin_hit;

   // Pin counts as active when enabled and at the selected level.
   always_comb begin
      pin_hit = pen_q && (pin_sync == logic'(level_q));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= LVL_LOW;
         pen_q   <= 1'b0;
         pat_q   <= '0;
      end else if (we) begin
         level_q <= brk_level_e'(wdata[LVL]);
         pen_q   <= wdata[PEN];
         pat_q   <= wdata[NUM_CH-1:0];
      end
   end

   // Software write wins in its own cycle; the pin sets the flag otherwise.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (we)      flag_q <= wdata[FLAG];
      else if (pin_hit) flag_q <= 1'b1;
   end

   always_comb begin
      rdata            = '0;
      rdata[NUM_CH-1:0] = pat_q;
      rdata[PEN]       = pen_q;
      rdata[FLAG]      = flag_q;
      rdata[LVL]       = logic'(level_q);
   end

   assign brk_active = flag_q;
   assign pattern    = pat_q;
endmodule

// File: rtl/brk_out_gate.sv
`timescale 1ns/1ps
module brk_out_gate #(
   parameter int unsigned NUM_CH = 4
) (
   input  logic              brk_active,
   input  logic [NUM_CH-1:0] pattern,
   input  logic [NUM_CH-1:0] raw,
   input  logic [NUM_CH-1:0] oe,
   output logic [NUM_CH-1:0] gated
);
   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic sel;
         always_comb begin
            sel = brk_active ? pattern[c] : raw[c];
            gated[c] = oe[c] & sel;
         end
      end
   endgenerate
endmodule

// File: rtl/pwm_break_guard.sv
`timescale 1ns/1ps
module pwm_break_guard #(
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned REG_W      = NUM_CH + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [NUM_CH-1:0] pwm_in,
   input  logic [NUM_CH-1:0] pwm_oe,
   input  logic              brk_in,
   output logic [NUM_CH-1:0] pwm_out
);
   logic              pin_sync;
   logic              brk_active;
   logic [NUM_CH-1:0] pattern;

   brk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (brk_in),
      .q     (pin_sync)
   );

   brk_ctrl_reg #(.NUM_CH(NUM_CH)) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (reg_we),
      .wdata      (reg_wdata),
      .pin_sync   (pin_sync),
      .rdata      (reg_rdata),
      .brk_active (brk_active),
      .pattern    (pattern)
   );

   brk_out_gate #(.NUM_CH(NUM_CH)) u_gate (
      .brk_active (brk_active),
      .pattern    (pattern),
      .raw        (pwm_in),
      .oe         (pwm_oe),
      .gated      (pwm_out)
   );
endmodule

// File: rtl/pwm_break_guard_chk.sv
`timescale 1ns/1ps
module pwm_break_guard_chk #(
   parameter int unsigned NUM_CH = 4,
   localparam int unsigned REG_W = NUM_CH + 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [REG_W-1:0]  reg_wdata,
   input logic [REG_W-1:0]  reg_rdata,
   input logic [NUM_CH-1:0] pwm_in,
   input logic [NUM_CH-1:0] pwm_oe,
   input logic              brk_in,
   input logic [NUM_CH-1:0] pwm_out
);
   localparam int unsigned PEN  = NUM_CH;
   localparam int unsigned FLAG = NUM_CH + 1;
   localparam int unsigned RSV  = NUM_CH + 3;

   p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[RSV] == 1'b0);

   p_write_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> reg_rdata[FLAG] == $past(reg_wdata[FLAG]));

   p_pin_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_we && !reg_rdata[FLAG] && !reg_rdata[PEN]) |=> !reg_rdata[FLAG]);

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_we && reg_rdata[FLAG]) |=> reg_rdata[FLAG]);

   p_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[FLAG] |-> (((pwm_out ^ reg_rdata[NUM_CH-1:0]) & pwm_oe) == '0));

   p_disabled_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_out & ~pwm_oe) == '0);

   p_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[FLAG] |-> (pwm_out == (pwm_in & pwm_oe)));
endmodule

bind pwm_break_guard pwm_break_guard_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .pwm_in    (pwm_in),
   .pwm_oe    (pwm_oe),
   .brk_in    (brk_in),
   .pwm_out   (pwm_out)
);

// File: tb/tb_pwm_break_guard.sv
`timescale 1ns/1ps
module tb_pwm_break_guard;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic [3:0] pwm_in = 4'h0;
   logic [3:0] pwm_oe = 4'h0;
   logic       brk_in = 1'b0;
   logic [3:0] pwm_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   pwm_break_guard dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .pwm_in(pwm_in), .pwm_oe(pwm_oe),
      .brk_in(brk_in), .pwm_out(pwm_out));

   // Behavioural reference: pin history as a queue, fields as plain bits.
   bit       m_lvl, m_flag, m_pen;
   bit [3:0] m_pat;
   bit       pin_hist[$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_lvl = 0; m_flag = 0; m_pen = 0; m_pat = 0;
         pin_hist = {1'b0, 1'b0};
      end else begin
         bit seen;
         seen = pin_hist[0];              // value two edges old
         void'(pin_hist.pop_front());
         pin_hist.push_back(brk_in);
         if (reg_we) begin
            m_lvl  = reg_wdata[6];
            m_flag = reg_wdata[5];
            m_pen  = reg_wdata[4];
            m_pat  = reg_wdata[3:0];
         end else if (m_pen && (seen == m_lvl)) begin
            m_flag = 1;
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Cycle-by-cycle comparison against the model.
   always begin
      @(negedge clk);
      #2;
      if (rst_n && !done) begin
         chk("R3 model rdata", reg_rdata, {1'b0, m_lvl, m_flag, m_pen, m_pat});
         chk("R10/R11/R12 model out", pwm_out,
             pwm_oe & (m_flag ? m_pat : pwm_in));
      end
   end

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] v);
      @(negedge clk);
      reg_we = 1'b1; reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      pwm_in = 4'hA; pwm_oe = 4'hF;
      tick(3);
      chk("R1 reset rdata", reg_rdata, 8'h00);
      rst_n = 1'b1;
      tick(1);
      chk("R1 rdata after reset", reg_rdata, 8'h00);
      pwm_oe = 4'h0; #1;
      chk("R1 out idle", pwm_out, 4'h0);
      pwm_oe = 4'hF; #1;
      chk("R12 pass-through", pwm_out, 4'hA);
      pwm_in = 4'h6; #1;
      chk("R12 same-cycle pass", pwm_out, 4'h6);
      pwm_in = 4'hA;

      // R2/R3: reserved bit, readback; pin disabled, high level.
      wr(8'hC5);
      chk("R2 reserved zero", reg_rdata, 8'h45);
      chk("R3 readback", reg_rdata[6:0], 7'h45);

      // R5: pin disabled, input active for many cycles.
      brk_in = 1'b1;
      tick(5);
      chk("R5 pin disabled flag", reg_rdata[5], 0);
      chk("R5 out unaffected", pwm_out, 4'hA);
      brk_in = 1'b0;
      tick(3);

      // R6: latency with pin enabled, high active.
      wr(8'h55);
      tick(1);
      brk_in = 1'b1;       // set before edge k
      tick(2);
      chk("R6 flag not yet after k+1", reg_rdata[5], 0);
      tick(1);
      chk("R6 flag set after k+2", reg_rdata[5], 1);
      chk("R4 high level active", reg_rdata[5], 1);
      chk("R10 pattern forced", pwm_out, 4'h5);

      // R7: sticky.
      brk_in = 1'b0;
      tick(4);
      chk("R7 flag sticky", reg_rdata[5], 1);

      // R11: disabled channels low during break.
      pwm_oe = 4'h3; #1;
      chk("R11 disabled low in break", pwm_out, 4'h1);
      pwm_oe = 4'hF;

      // R8: clear with input inactive.
      wr(8'h55);
      chk("R8 cleared", reg_rdata[5], 0);
      tick(3);
      chk("R8 stays clear", reg_rdata[5], 0);
      chk("R12 resumes pass", pwm_out, 4'hA);

      // R8: clear while input still active.
      brk_in = 1'b1;
      tick(4);
      chk("R6 flag set again", reg_rdata[5], 1);
      wr(8'h55);
      chk("R8 cleared for one cycle", reg_rdata[5], 0);
      tick(1);
      chk("R8 re-set next cycle", reg_rdata[5], 1);

      // R4: low level select with input high -> no trigger.
      wr(8'h15);
      tick(4);
      chk("R4 low select ignores high input", reg_rdata[5], 0);
      brk_in = 1'b0;
      tick(2);
      chk("R4 not yet", reg_rdata[5], 0);
      tick(1);
      chk("R4 low level active", reg_rdata[5], 1);

      // R9: software force with pin disabled.
      brk_in = 1'b1;
      wr(8'h03);
      tick(3);
      chk("R9 pin off stays clear", reg_rdata[5], 0);
      wr(8'h23);
      chk("R9 forced flag", reg_rdata, 8'h23);
      chk("R10 forced pattern", pwm_out, 4'h3);
      pwm_oe = 4'h0; #1;
      chk("R11 all disabled", pwm_out, 4'h0);
      pwm_oe = 4'hF;

      // Random traffic against the model.
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         pwm_in = 4'($urandom);
         pwm_oe = 4'($urandom);
         if (($urandom % 7) == 0) brk_in = ~brk_in;
         if (($urandom % 11) == 0) begin
            reg_we = 1'b1;
            reg_wdata = 8'($urandom);
         end else begin
            reg_we = 1'b0;
         end
      end
      reg_we = 1'b0;
      tick(2);
      finish_run();
   end
endmodule